// File: doc/BRIEF.md
# Kogge-Stone Parallel-Prefix Adder

This block adds two N-bit operands and a carry-in. All carries come from a parallel-prefix network of the Kogge-Stone kind. The carry-in sits at prefix position 0 as a group with generate equal to the carry-in and propagate equal to zero. Operand bit k sits at position k+1.

Each bit first forms a generate (AND) and a propagate (XOR). A tree of prefix levels then merges groups. At each level the reach doubles: 1, 2, 4, 8 and so on. The last level reaches position N, so the top prefix generate, which covers every position down to 0, is the carry-out. A position whose partner would fall below position 0 passes through a buffer. A position whose lower partner already reaches position 0 uses a cell that forms only the generate. All other positions use the full generate and propagate merge.

Each sum bit is the bit's propagate XOR the prefix generate one position below it. The sum and carry-out are registered, in line with a synchronous FPGA datapath. A parameter can also bring out the whole set of prefix generates, registered, for debug.

Top module: `ks_adder`

## Requirements
- R1: A rising edge with `rst` high sets `sum_o`, `c_out` and `grp_gen_o` to zero, whatever the operands are.
- R2: At the rising edge after operands are applied with `rst` low, `sum_o` takes the low N bits of `op_a + op_b + c_in`.
- R3: At that same edge, `c_out` takes bit N of `op_a + op_b + c_in`, which is the carry out of the top operand bit.
- R4: With `DBG_EN` = 1, bit k of `grp_gen_o` (k = 0..N) is the carry into operand bit k. This is bit k of `(op_a mod 2^k) + (op_b mod 2^k) + c_in`. So bit 0 equals `c_in` and bit N equals `c_out`. Every final prefix group reaches position 0.
- R5: With `DBG_EN` = 0, `grp_gen_o` stays at zero for every operand pattern.
- R6: A carry travels across the full width. All-ones plus zero with `c_in` = 1 gives a zero sum and `c_out` = 1. All-ones plus all-ones with `c_in` = 1 gives an all-ones sum and `c_out` = 1.
- R7: R2 and R3 hold for every operand pair and carry-in at N = 4 and N = 8, as well as at the default N = 16. N = 4 uses three prefix levels and N = 8 uses four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the results register on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| c_in | input | 1 | Carry-in, placed at prefix position 0 |
| sum_o | output | N | Registered sum |
| c_out | output | 1 | Registered carry-out |
| grp_gen_o | output | N+1 | Registered prefix generates for debug; zero when DBG_EN = 0 |

## Verification
The in-RTL properties check four things on every cycle outside reset:
- the final prefix generates follow the bit-serial carry recurrence from the bitwise generate and propagate terms;
- every final group propagate is zero;
- the registered sum and carry-out match a behavioural addition of the previous cycle's inputs;
- reset clears the outputs.

Other behaviours show only through the bench's scenarios:
- that the debug port is silent when disabled;
- that the 4-bit and 8-bit parameterisations, which need fewer levels, give the correct total for every input combination;
- that long carry chains such as all-ones plus one resolve correctly.

// File: rtl/ks_pkg.sv
package ks_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Full merge of an upper group with the adjoining lower group.
  function automatic gp_t ks_black(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Merge when the lower group already reaches position 0: the propagate is
  // then zero, since the position-0 propagate is zero.
  function automatic gp_t ks_gray(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/ks_bitpg.sv
module ks_bitpg #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N:0]   g,
  output logic [N:0]   p
);
  // Position 0 carries the carry-in as a pure generate.
  assign g[0] = cin;
  assign p[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : bit_gp
    assign g[i+1] = a[i] & b[i];
    assign p[i+1] = a[i] ^ b[i];
  end
endmodule

// File: rtl/ks_prefix.sv
module ks_prefix
  import ks_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N:0] g_in,
  input  logic [N:0] p_in,
  output logic [N:0] g_out,
  output logic [N:0] p_out
);
  localparam int POS    = N + 1;
  localparam int LEVELS = (POS > 1) ? $clog2(POS) : 1;

  for (genvar lvl = 1; lvl <= LEVELS; lvl++) begin : lv
    localparam int SPAN = 1 << (lvl - 1);
    logic [N:0] g_prev, p_prev, g_cur, p_cur;

    if (lvl == 1) begin : first
      assign g_prev = g_in;
      assign p_prev = p_in;
    end else begin : chain
      assign g_prev = lv[lvl-1].g_cur;
      assign p_prev = lv[lvl-1].p_cur;
    end

    for (genvar pos = 0; pos <= N; pos++) begin : node
      if (pos < SPAN) begin : buf_c
        assign g_cur[pos] = g_prev[pos];
        assign p_cur[pos] = p_prev[pos];
      end else if (pos < 2 * SPAN) begin : gray_c
        assign {g_cur[pos], p_cur[pos]} =
          ks_gray(gp_t'({g_prev[pos], p_prev[pos]}),
                  gp_t'({g_prev[pos-SPAN], p_prev[pos-SPAN]}));
      end else begin : black_c
        assign {g_cur[pos], p_cur[pos]} =
          ks_black(gp_t'({g_prev[pos], p_prev[pos]}),
                   gp_t'({g_prev[pos-SPAN], p_prev[pos-SPAN]}));
      end
    end
  end

  assign g_out = lv[LEVELS].g_cur;
  assign p_out = lv[LEVELS].p_cur;
endmodule

// File: rtl/ks_sum.sv
module ks_sum #(
  parameter int N = 16
) (
  input  logic [N-1:0] p_op,
  input  logic [N:0]   g_grp,
  output logic [N-1:0] sum,
  output logic         cout
);
  for (genvar i = 0; i < N; i++) begin : sbit
    assign sum[i] = p_op[i] ^ g_grp[i];
  end
  assign cout = g_grp[N];
endmodule

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int N      = 16,
  parameter bit DBG_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         c_in,
  output logic [N-1:0] sum_o,
  output logic         c_out,
  output logic [N:0]   grp_gen_o
);
  logic [N:0]   g_bit, p_bit, g_fin, p_fin;
  logic [N-1:0] sum_c;
  logic         cout_c;

  ks_bitpg #(.N(N)) u_pg (
    .a(op_a), .b(op_b), .cin(c_in), .g(g_bit), .p(p_bit)
  );

  ks_prefix #(.N(N)) u_tree (
    .g_in(g_bit), .p_in(p_bit), .g_out(g_fin), .p_out(p_fin)
  );

  ks_sum #(.N(N)) u_sum (
    .p_op(p_bit[N:1]), .g_grp(g_fin), .sum(sum_c), .cout(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o <= '0;
      c_out <= 1'b0;
    end else begin
      sum_o <= sum_c;
      c_out <= cout_c;
    end
  end

  if (DBG_EN) begin : dbg_on
    always_ff @(posedge clk) begin
      if (rst) grp_gen_o <= '0;
      else     grp_gen_o <= g_fin;
    end
  end else begin : dbg_off
    assign grp_gen_o = '0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum_o == '0 && c_out == 1'b0 && grp_gen_o == '0));

  // R2
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum_o == $past(op_a + op_b + {{(N-1){1'b0}}, c_in}));

  // R3
  cout_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> {c_out, sum_o} ==
      $past({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, c_in}));

  // R4
  full_span_chk: assert property (@(posedge clk) disable iff (rst)
    p_fin == '0 && g_fin[0] == c_in);

  for (genvar k = 1; k <= N; k++) begin : recur
    // R4
    carry_recur_chk: assert property (@(posedge clk) disable iff (rst)
      g_fin[k] == (g_bit[k] | (p_bit[k] & g_fin[k-1])));
  end
endmodule

// File: tb/ks_adder_test.sv
module ks_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [16:0] g16;
  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [8:0]  g8;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        c4 = 1'b0, co4;
  logic [4:0]  g4;

  int n_chk = 0;
  int n_err = 0;

  ks_adder #(.N(16), .DBG_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .c_in(c16),
    .sum_o(s16), .c_out(co16), .grp_gen_o(g16));
  ks_adder #(.N(8), .DBG_EN(1'b0)) uut8 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .c_in(c8),
    .sum_o(s8), .c_out(co8), .grp_gen_o(g8));
  ks_adder #(.N(4), .DBG_EN(1'b1)) uut4 (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .c_in(c4),
    .sum_o(s4), .c_out(co4), .grp_gen_o(g4));

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic longint carries(longint a, longint b, bit c, int w);
    longint r = 0;
    for (int k = 0; k <= w; k++) begin
      longint m = (longint'(1) << k) - 1;
      longint t = (a & m) + (b & m) + c;
      r |= ((t >> k) & 1) << k;
    end
    return r;
  endfunction

  // Applies a 16-bit vector just after a falling edge and checks it one edge later.
  task automatic apply16(logic [15:0] a, logic [15:0] b, logic c, string req);
    longint tot;
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    tot = longint'(a) + longint'(b) + c;
    check({req, " R2 sum"}, s16, tot & 16'hffff);
    check({req, " R3 cout"}, co16, (tot >> 16) & 1);
    check({req, " R4 carries"}, g16, carries(a, b, c, 16));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a16 = 16'hffff; b16 = 16'h0001; c16 = 1'b1;
    a8 = 8'hff; b8 = 8'h01; a4 = 4'hf; b4 = 4'h1;
    @(negedge clk); @(negedge clk);
    check("R1 reset sum16", s16, 0);
    check("R1 reset cout16", co16, 0);
    check("R1 reset grp16", g16, 0);
    check("R1 reset sum8", {co8, s8}, 0);
    check("R1 reset sum4", {co4, s4, g4}, 0);
    rst = 1'b0;
  endtask

  task automatic t_midreset();
    a16 = 16'h1234; b16 = 16'hfedc; c16 = 1'b1;
    @(negedge clk);
    check("R2 pre-reset sum", s16, (32'h1234 + 32'hfedc + 1) & 16'hffff);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-stream reset", {co16, s16}, 0);
    check("R1 mid-stream reset grp", g16, 0);
    rst = 1'b0;
  endtask

  task automatic t_corners();
    apply16(16'hffff, 16'h0000, 1'b1, "R6 ones+cin");
    check("R6 ones+cin zero sum", {co16, s16}, 17'h10000);
    apply16(16'hffff, 16'hffff, 1'b1, "R6 ones+ones+cin");
    check("R6 ones+ones+cin", {co16, s16}, 17'h1ffff);
    apply16(16'hffff, 16'h0001, 1'b0, "R6 ones+1");
    apply16(16'h7fff, 16'h0001, 1'b0, "R6 into msb");
    apply16(16'h8000, 16'h8000, 1'b0, "R3 msb pair");
    apply16(16'haaaa, 16'h5555, 1'b1, "R6 alternating");
    apply16(16'h5555, 16'h5555, 1'b0, "R2 repeat");
    apply16(16'h0000, 16'h0000, 1'b0, "R2 zero");
    apply16(16'h0000, 16'h0000, 1'b1, "R4 cin only");
  endtask

  task automatic t_random();
    for (int i = 0; i < 2000; i++)
      apply16(16'($urandom), 16'($urandom), 1'($urandom), "R2 random");
  endtask

  // Every 8-bit and 4-bit operand pair with both carry-in values.
  task automatic t_exhaustive();
    for (int v = 0; v < (1 << 17); v++) begin
      longint t8, t4;
      a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      @(negedge clk);
      t8 = longint'(v[7:0]) + longint'(v[15:8]) + v[16];
      check("R7 n8 total", {co8, s8}, t8);
      if (v < 512) begin
        t4 = longint'(v[3:0]) + longint'(v[7:4]) + v[8];
        check("R7 n4 total", {co4, s4}, t4);
        check("R4 n4 carries", g4, carries(v[3:0], v[7:4], v[8], 4));
      end
      if (v % 4096 == 0) check("R5 debug off", g8, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_random();
    t_exhaustive();
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule